// File: doc/BRIEF.md
# QPSK Hard-Decision Differential Decoder

This block sits at the end of a coherent QPSK receive chain. Each symbol arrives as a pair of signed decision values, one for the in-phase arm and one for the quadrature arm. The block slices each value to a hard bit and keeps the bit pair of the last accepted symbol. It then differentially decodes the new pair against that stored pair. Because the transmitter encodes differentially, the decoded bits come out the same whichever of the four 90-degree carrier phases the receiver locked to. The block does not need a sync pattern to resolve that ambiguity.

A synchronous clear is pulsed at the start of each burst. It zeroes the stored pair and marks the next decoded symbol as unreliable, because that symbol has no real predecessor. Decoded pairs are presented in parallel with a valid strobe. The same bits are also offered as a serial stream that sends the first output bit and then the second.

Top module: `qpsk_diff_slicer`

## Requirements
- R1: A decision value strictly greater than zero slices to bit 1. Zero and negative values slice to bit 0.
- R2: When the current I and Q bits are equal, `out_a` = I xor previous I and `out_b` = Q xor previous Q.
- R3: When the current I and Q bits differ, `out_a` = Q xor previous Q and `out_b` = I xor previous I.
- R4: The stored previous pair is updated only by a symbol with `in_vld` high. Decision values on cycles without `in_vld` have no effect on later outputs.
- R5: A `clr` pulse on an idle cycle sets the stored pair to (0,0). The next decoded symbol is the only one with `out_first` high.
- R6: `out_vld` is high exactly one clock after each cycle with `in_vld` high. `out_a`, `out_b` and `out_first` hold their values between valid outputs.
- R7: The serial output has `ser_vld` high and `ser_bit` equal to `out_a` in the cycle where `out_vld` is high. In the following cycle it has `ser_vld` high and `ser_bit` equal to `out_b`. This holds when valid inputs are at least two cycles apart.
- R8: After reset, all outputs are 0, the stored pair is (0,0), and the first decoded symbol is flagged with `out_first`.
- R9: When `clr` and `in_vld` are high in the same cycle, that symbol is decoded against a stored pair of (0,0) and flagged with `out_first`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Burst-start clear of the stored symbol |
| in_vld | input | 1 | Decision pair valid |
| dv_i | input | DW | Signed in-phase decision value |
| dv_q | input | DW | Signed quadrature decision value |
| out_vld | output | 1 | Decoded pair valid |
| out_a | output | 1 | First decoded bit |
| out_b | output | 1 | Second decoded bit |
| out_first | output | 1 | Decoded pair has no real predecessor |
| ser_vld | output | 1 | Serial bit valid |
| ser_bit | output | 1 | Serial decoded bit, first bit then second bit |

## Verification
The only state is the stored previous pair and the pending-first flag. A wrong stored pair therefore shows up in the very next decoded symbol, one cycle after that symbol's input. It then corrects itself, because each valid symbol overwrites the store. The bench feeds symbols that cover both the equal-bit and the differing-bit cases. Between symbols it drives junk decision values with the valid strobe low. It also pulses the clear both alone and together with a symbol, so that a leaked update or a missed clear corrupts a compared output within one symbol.

// File: rtl/qpsk_diff_slicer.sv
module qpsk_diff_slicer #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] dv_i,
  input  logic signed [DW-1:0] dv_q,
  output logic                 out_vld,
  output logic                 out_a,
  output logic                 out_b,
  output logic                 out_first,
  output logic                 ser_vld,
  output logic                 ser_bit
);

  localparam logic signed [DW-1:0] ZERO = '0;

  logic i_bit, q_bit, ip, qp, ip_eff, qp_eff, first_pend;
  logic x_bit, a_nxt, b_nxt, b_hold, b_pend;

  assign i_bit  = dv_i > ZERO;
  assign q_bit  = dv_q > ZERO;
  assign ip_eff = clr ? 1'b0 : ip;
  assign qp_eff = clr ? 1'b0 : qp;
  assign x_bit  = i_bit ^ q_bit;
  assign a_nxt  = x_bit ? (q_bit ^ qp_eff) : (i_bit ^ ip_eff);
  assign b_nxt  = x_bit ? (i_bit ^ ip_eff) : (q_bit ^ qp_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip <= 1'b0; qp <= 1'b0; first_pend <= 1'b1;
      out_vld <= 1'b0; out_a <= 1'b0; out_b <= 1'b0; out_first <= 1'b0;
      ser_vld <= 1'b0; ser_bit <= 1'b0; b_hold <= 1'b0; b_pend <= 1'b0;
    end else begin
      out_vld <= in_vld;
      ser_vld <= in_vld | b_pend;
      if (in_vld) begin
        out_a      <= a_nxt;
        out_b      <= b_nxt;
        out_first  <= clr | first_pend;
        ip         <= i_bit;
        qp         <= q_bit;
        first_pend <= 1'b0;
        ser_bit    <= a_nxt;
        b_hold     <= b_nxt;
        b_pend     <= 1'b1;
      end else begin
        if (clr) begin
          ip <= 1'b0; qp <= 1'b0; first_pend <= 1'b1;
        end
        if (b_pend) ser_bit <= b_hold;
        b_pend <= 1'b0;
      end
    end
  end

  // R6
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_a) && $stable(out_b) && $stable(out_first)));
  // R9
  first_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && clr) |=> out_first);
  // R7
  ser_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (ser_vld && ser_bit == out_a));
  // R7
  ser_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !in_vld) |=> (ser_vld && ser_bit == $past(out_b)));
  // R2
  same_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !clr && dv_i > ZERO && dv_q > ZERO) |=> (out_a == !$past(ip) && out_b == !$past(qp)));

endmodule

// File: tb/qpsk_diff_slicer_tb.sv
module qpsk_diff_slicer_tb;
  localparam int DW = 12;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_vld = 1'b0;
  logic signed [DW-1:0] dv_i = '0, dv_q = '0;
  logic out_vld, out_a, out_b, out_first, ser_vld, ser_bit;
  int n_chk = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  logic mi = 1'b0, mq = 1'b0, mfirst = 1'b1;
  logic pend_b = 1'b0, pend_val = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qpsk_diff_slicer #(.DW(DW)) u_dut (.clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
    .dv_i(dv_i), .dv_q(dv_q), .out_vld(out_vld), .out_a(out_a), .out_b(out_b),
    .out_first(out_first), .ser_vld(ser_vld), .ser_bit(ser_bit));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 slicing, R2/R3 decode, R5/R9 clear, model kept independently
  task automatic send(input int vi, input int vq, input bit c);
    logic bi, bq, pi, pq, a, b;
    @(negedge clk);
    bi = vi > 0; bq = vq > 0;
    pi = c ? 1'b0 : mi; pq = c ? 1'b0 : mq;
    if (bi == bq) begin a = bi ^ pi; b = bq ^ pq; end
    else begin a = bq ^ pq; b = bi ^ pi; end
    exp_q.push_back({mfirst | c, a, b});
    mi = bi; mq = bq; mfirst = 1'b0;
    dv_i = DW'(vi); dv_q = DW'(vq); clr = c; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; clr = 1'b0;
    dv_i = DW'(-vi + 7); dv_q = DW'(vq - 300);   // R4 junk while idle
  endtask

  task automatic idle_clr();
    @(negedge clk);
    clr = 1'b1; mi = 1'b0; mq = 1'b0; mfirst = 1'b1;
    dv_i = 12'sd100; dv_q = 12'sd100;
    @(negedge clk);
    clr = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (out_vld) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected out_vld", 1, 0);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check(out_first == e[2], "R5/R9 out_first", out_first, e[2]);
        check(out_a == e[1], "R2/R3 out_a", out_a, e[1]);
        check(out_b == e[0], "R2/R3 out_b", out_b, e[0]);
        check(ser_vld && ser_bit == e[1], "R7 serial A", {ser_vld, ser_bit}, {1'b1, e[1]});
        pend_b = 1'b1; pend_val = e[0];
      end
    end else if (pend_b) begin
      check(ser_vld && ser_bit == pend_val, "R7 serial B", {ser_vld, ser_bit}, {1'b1, pend_val});
      pend_b = 1'b0;
    end else begin
      check(!ser_vld, "R7 serial idle", ser_vld, 0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check({out_vld, out_a, out_b, out_first, ser_vld, ser_bit} == 6'b0, "R8 reset outputs",
          {out_vld, out_a, out_b, out_first, ser_vld, ser_bit}, 0);
    rst_n = 1'b1;
    send(5, 9, 1'b0);          // R8 first flagged, R2 against zero pair
    send(0, -4, 1'b0);         // R1 zero slices to 0
    send(1, 0, 1'b0);          // R3 differing bits
    send(-1, 2047, 1'b0);      // R3
    send(-2048, -3, 1'b0);     // R2
    send(300, 300, 1'b0);      // R2
    repeat (3) @(negedge clk); // R4 idle junk
    send(-7, 12, 1'b0);
    idle_clr();                // R5
    send(8, -8, 1'b0);
    send(8, 8, 1'b0);
    send(9, 9, 1'b1);          // R9 clear with symbol
    send(-9, -9, 1'b0);
    for (int k = 0; k < 40; k++)
      send(((k * 37) % 11) - 5, ((k * 53) % 13) - 6, (k % 17) == 16);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 missing outputs", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule